// File: doc/BRIEF.md
# Reset Sequencer with Watchdog Source

This block produces the single synchronous reset seen by a small processor core. It has two run-time sources. The first is an active-low external reset pin. The second is a one-clock time-out pulse from a watchdog timer. An asynchronous power-on reset input overrides both and puts every register in the block into a known state. All hold times are measured in machine cycles. A machine cycle is marked by an internal clock divider that produces one strobe every `CLKS_PER_MC` clocks. The divider restarts its phase whenever a timed hold begins, so each hold length is an exact number of clocks.

The pin passes through a two-flop synchronizer. It is accepted as a reset only after two machine-cycle strobes have seen it low. The internal reset then stays on for as long as the pin is held low. After the pin is released, the reset runs for a fixed two-machine-cycle tail. A watchdog time-out forces exactly two machine cycles of reset and sets a sticky flag that software can read. Pin resets and later watchdog resets leave that flag as it is. Only power-on reset or a software clear removes it.

When the core is in power-down, its clock is stopped. In that state a low pin raises a clock-restart request through a purely combinational path, so no clock edge is needed. The reset itself is applied only after the clock source reports that it is stable. Every reset ends with the core fetching from the restart vector, 0x0000. The block drives that vector as an output.

Top module: `rstctl_top`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1 and `wdt_flag` is 0. After `por_n` rises, `sys_rst` stays 1 for exactly 2·CLKS_PER_MC clock edges.
- R2: A low pulse on `pin_n` that is shorter than CLKS_PER_MC clocks causes no reset. A low level held for 2·CLKS_PER_MC+2 clocks asserts `sys_rst` within 2·CLKS_PER_MC+6 clocks of the falling edge.
- R3: `sys_rst` stays 1 while `pin_n` is held low. It falls exactly 2·CLKS_PER_MC+3 clock edges after `pin_n` rises (two synchronizer stages, one sequencer step, two machine cycles).
- R4: A one-clock `wdt_tmo` pulse seen while idle and not in power-down sets `sys_rst` at that edge. `sys_rst` then stays 1 for exactly 2·CLKS_PER_MC clocks.
- R5: A watchdog reset sets `wdt_flag` to 1. A pin reset never sets it.
- R6: `wdt_flag` keeps its value through pin resets and watchdog resets. It is cleared by a one-clock `flag_clr` pulse, except that a watchdog reset arriving in the same clock wins and the flag reads 1.
- R7: With `pdown`=1 and the clock stopped, driving `pin_n` low sets `clk_wake` to 1 with no clock edge. With `pdown`=1 and `pin_n`=1, `clk_wake` is 0.
- R8: After a power-down wake, `sys_rst` stays 0 while `clk_stable` is 0 and `clk_wake` stays 1. `sys_rst` becomes 1 at the first clock edge that sees `clk_stable`=1. It is then released as in R3.
- R9: `rst_vector` always reads 0x0000.
- R10: A `wdt_tmo` pulse that arrives while a pin reset is active is ignored. `wdt_flag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (stopped during power-down) |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_n | input | 1 | Raw external reset pin, active low |
| pdown | input | 1 | Core is in power-down with its clock stopped |
| clk_stable | input | 1 | Clock source reports a stable restarted clock |
| wdt_tmo | input | 1 | One-clock watchdog time-out pulse |
| flag_clr | input | 1 | One-clock software clear of the watchdog flag |
| sys_rst | output | 1 | Synchronous internal reset to the core, active high |
| clk_wake | output | 1 | Asynchronous clock-restart request |
| wdt_flag | output | 1 | Sticky watchdog-reset flag |
| rst_vector | output | VEC_W | Program-counter restart address |

## Verification
The assertions check the following on every cycle:
- The strobe never fires on two clocks in a row.
- Pin qualification only ever advances on a strobe.
- The flag only rises after a time-out and never falls without a clear.
- A held pin keeps the sequencer in its hold state.
- A wake waits for clock stability.

Exact release counts can only be shown by the bench's scenarios. So can the rejection of short glitches, the purely combinational wake while the clock is stopped, and the priority between clear and set and between pin and watchdog sources.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAKE    = 3'd1,
    ST_PINHOLD = 3'd2,
    ST_TAIL    = 3'd3,
    ST_WDTHOLD = 3'd4
  } rst_state_e;
endpackage

// File: rtl/rstctl_mcdiv.sv
// Machine-cycle strobe generator with a synchronous phase restart.
module rstctl_mcdiv #(
  parameter int CLKS_PER_MC = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic resync,
  output logic mc_stb
);
  generate
    if (CLKS_PER_MC <= 1) begin : g_every
      assign mc_stb = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(CLKS_PER_MC);
      logic [W-1:0] div_q;

      assign mc_stb = (div_q == W'(CLKS_PER_MC - 1));

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)               div_q <= '0;
        else if (resync || mc_stb) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end

      // Strobe is a single clock wide and never repeats on the next clock.
      assert_stb_spacing_R2: assert property (@(posedge clk) disable iff (!por_n)
        mc_stb |=> !mc_stb);
    end
  endgenerate
endmodule

// File: rtl/rstctl_pinqual.sv
// Two-flop synchronizer and low-time qualifier for the external reset pin.
module rstctl_pinqual #(
  parameter int QUAL_MC = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  input  logic mc_stb,
  output logic pin_low,
  output logic pin_ok
);
  localparam int CW = $clog2(QUAL_MC + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                   cnt_q <= '0;
    else if (s2_q)                                cnt_q <= '0;
    else if (mc_stb && cnt_q != CW'(QUAL_MC))     cnt_q <= cnt_q + 1'b1;
  end

  assign pin_low = !s2_q;
  assign pin_ok  = (cnt_q == CW'(QUAL_MC));

  // Qualification is reached only on a strobe that sampled the pin low.
  assert_qual_on_strobe_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pin_ok) |-> ($past(mc_stb) && $past(!s2_q)));
endmodule

// File: rtl/rstctl_seq.sv
// Reset sequencer: source priority, hold timing and the sticky watchdog flag.
module rstctl_seq
  import rstctl_pkg::*;
#(
  parameter int HOLD_MC = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic mc_stb,
  input  logic pin_low,
  input  logic pin_ok,
  input  logic pdown,
  input  logic clk_stable,
  input  logic wdt_tmo,
  input  logic flag_clr,
  output logic in_reset,
  output logic wake_req,
  output logic resync,
  output logic wdt_flag
);
  localparam int HW = (HOLD_MC > 1) ? $clog2(HOLD_MC) : 1;

  rst_state_e    st_q, st_nxt;
  logic [HW-1:0] hcnt_q;
  logic          hold_done;
  logic          timed_st;
  logic          wdt_take;

  assign timed_st  = (st_q == ST_TAIL) || (st_q == ST_WDTHOLD);
  assign hold_done = mc_stb && (hcnt_q == HW'(HOLD_MC - 1));

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pdown && pin_low)       st_nxt = ST_WAKE;
        else if (!pdown && pin_ok)  st_nxt = ST_PINHOLD;
        else if (!pdown && wdt_tmo) st_nxt = ST_WDTHOLD;
      end
      ST_WAKE:    if (clk_stable) st_nxt = ST_PINHOLD;
      ST_PINHOLD: if (!pin_low)   st_nxt = ST_TAIL;
      ST_TAIL, ST_WDTHOLD: begin
        if (pin_ok)         st_nxt = ST_PINHOLD;
        else if (hold_done) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign resync   = (st_nxt != st_q) && ((st_nxt == ST_TAIL) || (st_nxt == ST_WDTHOLD));
  assign wdt_take = (st_q == ST_IDLE) && (st_nxt == ST_WDTHOLD);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q   <= ST_TAIL;
      hcnt_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (resync)                 hcnt_q <= '0;
      else if (mc_stb && timed_st) hcnt_q <= hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        wdt_flag <= 1'b0;
    else if (wdt_take) wdt_flag <= 1'b1;
    else if (flag_clr) wdt_flag <= 1'b0;
  end

  assign in_reset = (st_q == ST_PINHOLD) || timed_st;
  assign wake_req = (st_q == ST_WAKE);

  assert_wdt_sets_flag_R5: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_IDLE && !pdown && !pin_ok && wdt_tmo) |=> (wdt_flag && st_q == ST_WDTHOLD));

  assert_flag_rise_src_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_flag) |-> $past(wdt_tmo));

  assert_flag_keep_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_flag && !flag_clr) |=> wdt_flag);

  assert_pin_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_PINHOLD && pin_low) |=> (st_q == ST_PINHOLD));

  assert_wake_wait_R8: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_WAKE && !clk_stable) |=> (st_q == ST_WAKE && !in_reset));

  assert_wdt_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_WDTHOLD && !mc_stb && !pin_ok) |=> (st_q == ST_WDTHOLD));
endmodule

// File: rtl/rstctl_top.sv
// Reset controller top: pin and watchdog sources, power-down wake, restart vector.
module rstctl_top #(
  parameter int          CLKS_PER_MC  = 4,
  parameter int          QUAL_MC      = 2,
  parameter int          HOLD_MC      = 2,
  parameter int          VEC_W        = 16,
  parameter logic [31:0] RESTART_ADDR = 32'h0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pin_n,
  input  logic             pdown,
  input  logic             clk_stable,
  input  logic             wdt_tmo,
  input  logic             flag_clr,
  output logic             sys_rst,
  output logic             clk_wake,
  output logic             wdt_flag,
  output logic [VEC_W-1:0] rst_vector
);
  logic mc_stb, resync, pin_low, pin_ok, in_reset, wake_req;

  rstctl_mcdiv #(.CLKS_PER_MC(CLKS_PER_MC)) u_div (
    .clk    (clk),
    .por_n  (por_n),
    .resync (resync),
    .mc_stb (mc_stb)
  );

  rstctl_pinqual #(.QUAL_MC(QUAL_MC)) u_qual (
    .clk     (clk),
    .por_n   (por_n),
    .pin_n   (pin_n),
    .mc_stb  (mc_stb),
    .pin_low (pin_low),
    .pin_ok  (pin_ok)
  );

  rstctl_seq #(.HOLD_MC(HOLD_MC)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .mc_stb     (mc_stb),
    .pin_low    (pin_low),
    .pin_ok     (pin_ok),
    .pdown      (pdown),
    .clk_stable (clk_stable),
    .wdt_tmo    (wdt_tmo),
    .flag_clr   (flag_clr),
    .in_reset   (in_reset),
    .wake_req   (wake_req),
    .resync     (resync),
    .wdt_flag   (wdt_flag)
  );

  // The wake path uses the raw pin so it works with the clock stopped.
  assign clk_wake   = (pdown && !pin_n) || wake_req;
  assign sys_rst    = !por_n || in_reset;
  assign rst_vector = RESTART_ADDR[VEC_W-1:0];

  assert_wake_held_R8: assert property (@(posedge clk) disable iff (!por_n)
    (wake_req && !clk_stable) |=> (clk_wake && !sys_rst));
endmodule

// File: tb/rstctl_top_test.sv
module rstctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 4;

  logic clk = 1'b0;
  logic clk_en = 1'b1;
  logic por_n, pin_n, pdown, clk_stable, wdt_tmo, flag_clr;
  logic sys_rst, clk_wake, wdt_flag;
  logic [15:0] rst_vector;

  int total = 0;
  int bad = 0;
  bit exp_flag = 1'b0;

  rstctl_top #(.CLKS_PER_MC(CPM)) uut (
    .clk(clk), .por_n(por_n), .pin_n(pin_n), .pdown(pdown),
    .clk_stable(clk_stable), .wdt_tmo(wdt_tmo), .flag_clr(flag_clr),
    .sys_rst(sys_rst), .clk_wake(clk_wake), .wdt_flag(wdt_flag),
    .rst_vector(rst_vector)
  );

  always begin
    #(CLK_PERIOD/2);
    if (clk_en) clk = ~clk;
  end

  function automatic int release_edges_pin();
    return 2*CPM + 3;
  endfunction

  function automatic int wdt_edges();
    return 2*CPM + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (sys_rst && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic fire_wdt(input bit with_clr, output int n);
    wdt_tmo = 1'b1;
    flag_clr = with_clr;
    @(negedge clk);
    wdt_tmo = 1'b0;
    flag_clr = 1'b0;
    n = 1;
    while (sys_rst && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int len;
    int seed;
    bit seen;
    seed = 11;
    void'($urandom(seed));
    por_n = 1'b0; pin_n = 1'b1; pdown = 1'b0; clk_stable = 1'b1;
    wdt_tmo = 1'b0; flag_clr = 1'b0;
    tick(3);
    chk(sys_rst == 1'b1, "R1 reset held", sys_rst, 1);
    chk(wdt_flag == 1'b0, "R1 flag cleared", wdt_flag, 0);
    chk(rst_vector == 16'h0000, "R9 vector", rst_vector, 0);
    por_n = 1'b1;
    count_release(n);
    chk(n == 2*CPM, "R1 release edges", n, 2*CPM);

    // R4/R5: watchdog reset length and flag
    tick(3);
    fire_wdt(1'b0, n);
    exp_flag = 1'b1;
    chk(n == wdt_edges(), "R4 wdt hold edges", n, wdt_edges());
    chk(wdt_flag == exp_flag, "R5 flag set by wdt", wdt_flag, exp_flag);

    // R6: flag survives a pin reset; R3 release timing
    tick(3);
    pin_n = 1'b0;
    tick(3*CPM + 4);
    chk(sys_rst == 1'b1, "R3 held while pin low", sys_rst, 1);
    pin_n = 1'b1;
    count_release(n);
    chk(n == release_edges_pin(), "R3 pin release edges", n, release_edges_pin());
    chk(wdt_flag == 1'b1, "R6 flag kept over pin reset", wdt_flag, 1);

    // R6: flag kept over a second watchdog reset, then cleared
    tick(2);
    fire_wdt(1'b0, n);
    chk(wdt_flag == 1'b1, "R6 flag kept over wdt reset", wdt_flag, 1);
    tick(2);
    pulse_clr();
    exp_flag = 1'b0;
    chk(wdt_flag == 1'b0, "R6 flag cleared by software", wdt_flag, 0);

    // R10 and R5: wdt during a pin reset is ignored, pin reset sets no flag
    pin_n = 1'b0;
    tick(3*CPM + 4);
    wdt_tmo = 1'b1;
    tick(1);
    wdt_tmo = 1'b0;
    tick(2);
    chk(wdt_flag == 1'b0, "R10 wdt ignored in pin reset", wdt_flag, 0);
    chk(sys_rst == 1'b1, "R10 pin reset still held", sys_rst, 1);
    pin_n = 1'b1;
    count_release(n);
    chk(n == release_edges_pin(), "R3 release after ignored wdt", n, release_edges_pin());
    chk(wdt_flag == 1'b0, "R5 pin reset sets no flag", wdt_flag, 0);

    // R6: set beats clear in the same clock
    tick(3);
    fire_wdt(1'b1, n);
    exp_flag = 1'b1;
    chk(wdt_flag == 1'b1, "R6 set wins over clear", wdt_flag, 1);
    chk(n == wdt_edges(), "R4 wdt hold edges with clear", n, wdt_edges());

    // R2: long pin low is qualified
    tick(3);
    pin_n = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 2*CPM + 6; i++) begin
      @(negedge clk);
      if (sys_rst) seen = 1'b1;
    end
    chk(seen, "R2 long low qualified", seen, 1);
    pin_n = 1'b1;
    count_release(n);

    // Random mix: glitches, watchdog pulses, clears
    for (int it = 0; it < 30; it++) begin
      int r;
      tick(3 + ($urandom % 4));
      r = $urandom % 3;
      if (r == 0) begin
        len = 1 + ($urandom % (CPM - 1));
        pin_n = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < len; i++) begin
          @(negedge clk);
          if (sys_rst) seen = 1'b1;
        end
        pin_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          if (sys_rst) seen = 1'b1;
        end
        chk(!seen, "R2 glitch ignored", seen, 0);
        chk(wdt_flag == exp_flag, "R6 flag after glitch", wdt_flag, exp_flag);
      end else if (r == 1) begin
        fire_wdt(1'b0, n);
        exp_flag = 1'b1;
        chk(n == wdt_edges(), "R4 random wdt edges", n, wdt_edges());
        chk(wdt_flag == exp_flag, "R5 random wdt flag", wdt_flag, exp_flag);
      end else begin
        pulse_clr();
        exp_flag = 1'b0;
        chk(wdt_flag == exp_flag, "R6 random clear", wdt_flag, exp_flag);
      end
    end

    // R7/R8: power-down wake with the clock stopped
    tick(4);
    pdown = 1'b1;
    clk_stable = 1'b0;
    clk_en = 1'b0;
    #(CLK_PERIOD * 3);
    chk(clk_wake == 1'b0, "R7 no wake with pin high", clk_wake, 0);
    pin_n = 1'b0;
    #1;
    chk(clk_wake == 1'b1, "R7 async wake", clk_wake, 1);
    chk(sys_rst == 1'b0, "R8 no reset while clock stopped", sys_rst, 0);
    #(CLK_PERIOD * 2);
    clk_en = 1'b1;
    tick(6);
    chk(sys_rst == 1'b0, "R8 reset waits for stable", sys_rst, 0);
    chk(clk_wake == 1'b1, "R8 wake held", clk_wake, 1);
    clk_stable = 1'b1;
    tick(1);
    chk(sys_rst == 1'b1, "R8 reset after stable", sys_rst, 1);
    pdown = 1'b0;
    tick(2);
    pin_n = 1'b1;
    count_release(n);
    chk(n == release_edges_pin(), "R8 release after wake", n, release_edges_pin());

    // R1: power-on reset clears a set flag
    tick(2);
    fire_wdt(1'b0, n);
    chk(wdt_flag == 1'b1, "R5 flag set before por", wdt_flag, 1);
    por_n = 1'b0;
    #1;
    chk(wdt_flag == 1'b0, "R1 por clears flag", wdt_flag, 0);
    chk(sys_rst == 1'b1, "R1 por asserts reset", sys_rst, 1);
    tick(2);
    por_n = 1'b1;
    count_release(n);
    chk(n == 2*CPM, "R1 second release edges", n, 2*CPM);
    chk(rst_vector == 16'h0000, "R9 vector at end", rst_vector, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule